// File: doc/BRIEF.md
# Bus Host Write-Data Wiping Adapter

This block sits between a processor's load/store port and a request channel that follows a valid/ready handshake. It registers each accepted request into an outgoing flit and presents the address, byte mask, write enable and data unchanged for as long as the flit is held. Once the flit has been taken and no new request follows, the data lines stop showing the last transferred word and show a scrub value instead. This keeps confidential write data from sitting on the bus for many cycles after a word transfer.

A two-bit policy input chooses the scrub value. One code keeps the legacy behaviour, where the last word stays on the bus, so software can always undo the hardware policy. Other codes select all zeros or a pseudo-random word from an internal 32-bit Galois LFSR. The policy is sampled only at flit boundaries. A flit that is stalled by backpressure never changes, whatever happens on the policy input.

Top module: `bus_wipe_host`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next outputs are `bus_valid_o`=0 and `bus_data_o`, `bus_addr_o`, `bus_mask_o` and `bus_we_o` all zero.
- R2: `cpu_gnt_o` is high exactly when no flit is held or `bus_ready_i` is high. When `cpu_req_i` and `cpu_gnt_o` are both high at an edge, the cycle after that edge shows `bus_valid_o`=1 with the address, mask, write enable and data taken unchanged from the processor inputs.
- R3: While `bus_valid_o` is high and `bus_ready_i` is low, `cpu_gnt_o` is low, and at the next edge every bus output keeps its value and valid stays high.
- R4: Policy code 1 (zero) and the spare code 3 behave the same way. At a free slot, meaning `cpu_gnt_o` high with no request, the next data output is all zeros.
- R5: Policy code 0 (off) keeps the last transferred word on the data lines at a free slot. Processor write data presented without a request never reaches the bus.
- R6: Policy code 2 (random) places the LFSR word on the data lines at a free slot. The LFSR shifts right, and when the bit shifted out is 1 it XORs taps 32'h80200003 into the state. It restarts from seed 32'hACE12468 at reset. The first word shown after reset is the seed, and the LFSR steps once per random free slot and at no other time.
- R7: The policy input has no effect while a flit is held under backpressure. Its value is used only at the edge where the flit is released.
- R8: Back-to-back requests with `bus_ready_i` high each appear for exactly one cycle, with no scrub word between them.
- R9: At a free slot, `bus_valid_o` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wipe_mode_i | input | 2 | Scrub policy: 0 off, 1 zero, 2 random, 3 as zero |
| cpu_req_i | input | 1 | Processor request |
| cpu_addr_i | input | 32 | Request address |
| cpu_wdata_i | input | 32 | Write data |
| cpu_be_i | input | 4 | Byte mask |
| cpu_we_i | input | 1 | Write enable |
| cpu_gnt_o | output | 1 | Request accepted this cycle |
| bus_valid_o | output | 1 | Flit valid |
| bus_addr_o | output | 32 | Flit address |
| bus_mask_o | output | 4 | Flit byte mask |
| bus_we_o | output | 1 | Flit write enable |
| bus_data_o | output | 32 | Flit data, or the scrub value when idle |
| bus_ready_i | input | 1 | Channel ready |

## Verification
The bench goes after the policy input changing while a flit is stalled. A design that samples the policy too early would overwrite held data and break the handshake. It checks the off policy with unrequested write data toggling, where a leaky design would show data that was never issued. It checks the random policy word by word against its own LFSR model, starting from the seed. A generator that steps during stalls or during accepted requests then drifts out of sequence. It also checks back-to-back flits, where a design that inserts a scrub cycle would lose throughput, and the spare policy code, which must never fall back to leaving data on the bus.

// File: rtl/wipe_pkg.sv
package wipe_pkg;

    parameter int unsigned ADDR_W = 32;
    parameter int unsigned DATA_W = 32;
    localparam int unsigned MASK_W = DATA_W / 8;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_ZERO = 2'd1,
        MODE_RAND = 2'd2,
        MODE_SPARE = 2'd3
    } wipe_mode_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [MASK_W-1:0] mask;
        logic [DATA_W-1:0] data;
    } req_flit_t;

    // One right-shift step of a Galois generator.
    function automatic logic [DATA_W-1:0] galois_next(
        input logic [DATA_W-1:0] state,
        input logic [DATA_W-1:0] taps
    );
        logic [DATA_W-1:0] nxt;
        nxt = state >> 1;
        if (state[0]) nxt = nxt ^ taps;
        return nxt;
    endfunction

endpackage

// File: rtl/wipe_lfsr.sv
module wipe_lfsr
    import wipe_pkg::*;
#(
    parameter int unsigned          W    = DATA_W,
    parameter logic [DATA_W-1:0]    SEED = 32'hACE12468,
    parameter logic [DATA_W-1:0]    TAPS = 32'h80200003
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    output logic [DATA_W-1:0] word_o
);

    // An all-zero seed would lock the generator; replace it.
    localparam logic [DATA_W-1:0] SEED_SAFE = (SEED == '0) ? {{(DATA_W-1){1'b0}}, 1'b1} : SEED;

    logic [DATA_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED_SAFE;
        end else if (step_i) begin
            state_q <= galois_next(state_q, TAPS);
        end
    end

    assign word_o = state_q;

endmodule

// File: rtl/wipe_value_sel.sv
module wipe_value_sel
    import wipe_pkg::*;
(
    input  wipe_mode_e        mode_i,
    input  logic [DATA_W-1:0] last_data_i,
    input  logic [DATA_W-1:0] rand_word_i,
    output logic [DATA_W-1:0] wipe_data_o,
    output logic              uses_rand_o
);

    always_comb begin
        wipe_data_o = '0;
        uses_rand_o = 1'b0;
        unique case (mode_i)
            MODE_OFF:  wipe_data_o = last_data_i;
            MODE_RAND: begin
                wipe_data_o = rand_word_i;
                uses_rand_o = 1'b1;
            end
            MODE_ZERO, MODE_SPARE: wipe_data_o = '0;
            default:   wipe_data_o = '0;
        endcase
    end

endmodule

// File: rtl/wipe_flit_reg.sv
module wipe_flit_reg
    import wipe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  req_flit_t         flit_i,
    input  logic              idle_i,
    input  logic [DATA_W-1:0] wipe_data_i,
    output logic              valid_o,
    output req_flit_t         flit_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            flit_o  <= '0;
        end else if (load_i) begin
            valid_o <= 1'b1;
            flit_o  <= flit_i;
        end else if (idle_i) begin
            valid_o     <= 1'b0;
            flit_o.data <= wipe_data_i;
        end
    end

endmodule

// File: rtl/bus_wipe_host.sv
module bus_wipe_host
    import wipe_pkg::*;
#(
    parameter logic [DATA_W-1:0] LFSR_SEED = 32'hACE12468,
    parameter logic [DATA_W-1:0] LFSR_TAPS = 32'h80200003
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        wipe_mode_i,
    input  logic              cpu_req_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    input  logic [MASK_W-1:0] cpu_be_i,
    input  logic              cpu_we_i,
    output logic              cpu_gnt_o,
    output logic              bus_valid_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [MASK_W-1:0] bus_mask_o,
    output logic              bus_we_o,
    output logic [DATA_W-1:0] bus_data_o,
    input  logic              bus_ready_i
);

    req_flit_t         in_flit;
    req_flit_t         cur_flit;
    logic              valid_q;
    logic              slot_free;
    logic              accept;
    logic              idle_slot;
    logic [DATA_W-1:0] rand_word;
    logic [DATA_W-1:0] wipe_data;
    logic              uses_rand;
    wipe_mode_e        mode;

    assign mode      = wipe_mode_e'(wipe_mode_i);
    assign slot_free = !valid_q || bus_ready_i;
    assign accept    = slot_free && cpu_req_i;
    assign idle_slot = slot_free && !cpu_req_i;

    assign in_flit.we   = cpu_we_i;
    assign in_flit.addr = cpu_addr_i;
    assign in_flit.mask = cpu_be_i;
    assign in_flit.data = cpu_wdata_i;

    wipe_lfsr #(
        .SEED (LFSR_SEED),
        .TAPS (LFSR_TAPS)
    ) u_lfsr (
        .clk    (clk),
        .rst    (rst),
        .step_i (idle_slot && uses_rand),
        .word_o (rand_word)
    );

    wipe_value_sel u_sel (
        .mode_i      (mode),
        .last_data_i (cur_flit.data),
        .rand_word_i (rand_word),
        .wipe_data_o (wipe_data),
        .uses_rand_o (uses_rand)
    );

    wipe_flit_reg u_flit (
        .clk         (clk),
        .rst         (rst),
        .load_i      (accept),
        .flit_i      (in_flit),
        .idle_i      (idle_slot),
        .wipe_data_i (wipe_data),
        .valid_o     (valid_q),
        .flit_o      (cur_flit)
    );

    assign cpu_gnt_o   = slot_free;
    assign bus_valid_o = valid_q;
    assign bus_addr_o  = cur_flit.addr;
    assign bus_mask_o  = cur_flit.mask;
    assign bus_we_o    = cur_flit.we;
    assign bus_data_o  = cur_flit.data;

endmodule

// File: rtl/bus_wipe_host_chk.sv
module bus_wipe_host_chk
    import wipe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        wipe_mode_i,
    input logic              cpu_req_i,
    input logic [DATA_W-1:0] cpu_wdata_i,
    input logic              cpu_gnt_o,
    input logic              bus_valid_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [MASK_W-1:0] bus_mask_o,
    input logic [DATA_W-1:0] bus_data_o,
    input logic              bus_ready_i
);

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_req_i && cpu_gnt_o) |=> (bus_valid_o && bus_data_o == $past(cpu_wdata_i)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_valid_o && !bus_ready_i) |=>
            (bus_valid_o && $stable(bus_data_o) && $stable(bus_addr_o) && $stable(bus_mask_o)));

    assert_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_gnt_o && !cpu_req_i && wipe_mode_i[0]) |=> (bus_data_o == '0));

    assert_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_gnt_o && !cpu_req_i && wipe_mode_i == 2'd0) |=> $stable(bus_data_o));

    assert_rand_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_gnt_o && !cpu_req_i && wipe_mode_i == 2'd2) |=> (bus_data_o != '0));

    assert_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (cpu_gnt_o && !cpu_req_i) |=> !bus_valid_o);

endmodule

bind bus_wipe_host bus_wipe_host_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wipe_mode_i (wipe_mode_i),
    .cpu_req_i   (cpu_req_i),
    .cpu_wdata_i (cpu_wdata_i),
    .cpu_gnt_o   (cpu_gnt_o),
    .bus_valid_o (bus_valid_o),
    .bus_addr_o  (bus_addr_o),
    .bus_mask_o  (bus_mask_o),
    .bus_data_o  (bus_data_o),
    .bus_ready_i (bus_ready_i)
);

// File: tb/sim_bus_wipe_host.sv
`timescale 1ns/1ps
module sim_bus_wipe_host;

    localparam logic [31:0] SEED = 32'hACE12468;
    localparam logic [31:0] TAPS = 32'h80200003;
    localparam int NV = 15;

    typedef struct packed {
        logic [1:0]  mode;
        logic        req;
        logic [31:0] wd;
        logic        rdy;
        logic        ev;
        logic [31:0] ed;
        logic        rnd;
    } vec_t;

    // Expected values are the outputs after the edge that follows the drive.
    localparam vec_t TBL [NV] = '{
        '{2'd1, 1'b1, 32'hA1A1A1A1, 1'b1, 1'b1, 32'hA1A1A1A1, 1'b0}, // R2
        '{2'd1, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h00000000, 1'b0}, // R4 R9
        '{2'd0, 1'b1, 32'hB2B2B2B3, 1'b1, 1'b1, 32'hB2B2B2B3, 1'b0}, // R2
        '{2'd0, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 32'hB2B2B2B3, 1'b0}, // R5
        '{2'd0, 1'b0, 32'h5555AAAA, 1'b1, 1'b0, 32'hB2B2B2B3, 1'b0}, // R5
        '{2'd2, 1'b1, 32'hC3C3C3C3, 1'b0, 1'b1, 32'hC3C3C3C3, 1'b0}, // R2
        '{2'd2, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b1, 32'hC3C3C3C3, 1'b0}, // R3
        '{2'd1, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b1, 32'hC3C3C3C3, 1'b0}, // R7
        '{2'd2, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h00000000, 1'b1}, // R6
        '{2'd2, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h00000000, 1'b1}, // R6
        '{2'd2, 1'b1, 32'hD4D4D4D4, 1'b1, 1'b1, 32'hD4D4D4D4, 1'b0}, // R8
        '{2'd2, 1'b1, 32'hE5E5E5E5, 1'b1, 1'b1, 32'hE5E5E5E5, 1'b0}, // R8
        '{2'd1, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h00000000, 1'b0}, // R4
        '{2'd3, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h00000000, 1'b0}, // R4
        '{2'd2, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h00000000, 1'b1}  // R6
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  wipe_mode_i = 2'd0;
    logic        cpu_req_i = 1'b0;
    logic [31:0] cpu_addr_i = '0;
    logic [31:0] cpu_wdata_i = '0;
    logic [3:0]  cpu_be_i = '0;
    logic        cpu_we_i = 1'b0;
    logic        cpu_gnt_o;
    logic        bus_valid_o;
    logic [31:0] bus_addr_o;
    logic [3:0]  bus_mask_o;
    logic        bus_we_o;
    logic [31:0] bus_data_o;
    logic        bus_ready_i = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [31:0] ref_lfsr = SEED;

    always #2 clk = ~clk;

    bus_wipe_host u0 (
        .clk         (clk),
        .rst         (rst),
        .wipe_mode_i (wipe_mode_i),
        .cpu_req_i   (cpu_req_i),
        .cpu_addr_i  (cpu_addr_i),
        .cpu_wdata_i (cpu_wdata_i),
        .cpu_be_i    (cpu_be_i),
        .cpu_we_i    (cpu_we_i),
        .cpu_gnt_o   (cpu_gnt_o),
        .bus_valid_o (bus_valid_o),
        .bus_addr_o  (bus_addr_o),
        .bus_mask_o  (bus_mask_o),
        .bus_we_o    (bus_we_o),
        .bus_data_o  (bus_data_o),
        .bus_ready_i (bus_ready_i)
    );

    function automatic logic [31:0] step_ref(input logic [31:0] s);
        logic [31:0] n;
        n = {1'b0, s[31:1]};
        if (s[0]) n = n ^ TAPS;
        return n;
    endfunction

    function automatic logic [31:0] addr_of(input logic [31:0] d);
        return {d[15:0], d[31:16]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic r, input logic [31:0] d, input logic rd);
        wipe_mode_i = m;
        cpu_req_i   = r;
        cpu_wdata_i = d;
        cpu_addr_i  = addr_of(d);
        cpu_be_i    = d[3:0];
        cpu_we_i    = d[0];
        bus_ready_i = rd;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", {31'b0, bus_valid_o}, 32'd0);
        chk("R1 data", bus_data_o, 32'd0);
        chk("R1 addr", bus_addr_o, 32'd0);
        chk("R1 mask", {28'b0, bus_mask_o}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].mode, TBL[i].req, TBL[i].wd, TBL[i].rdy);
            @(negedge clk);
            chk($sformatf("row%0d valid R2/R9", i), {31'b0, bus_valid_o}, {31'b0, TBL[i].ev});
            if (TBL[i].rnd) begin
                chk($sformatf("row%0d R6 rand word", i), bus_data_o, ref_lfsr);
                ref_lfsr = step_ref(ref_lfsr);
            end else begin
                chk($sformatf("row%0d data R2-R8", i), bus_data_o, TBL[i].ed);
            end
            if (TBL[i].ev) begin
                chk($sformatf("row%0d addr R2", i), bus_addr_o, addr_of(TBL[i].ed));
                chk($sformatf("row%0d mask R2", i), {28'b0, bus_mask_o}, {28'b0, TBL[i].ed[3:0]});
                chk($sformatf("row%0d we R2", i), {31'b0, bus_we_o}, {31'b0, TBL[i].ed[0]});
            end
        end

        // R3: grant low while a held flit is stalled
        drive(2'd1, 1'b1, 32'h12345678, 1'b0);
        @(negedge clk);
        chk("R3 held valid", {31'b0, bus_valid_o}, 32'd1);
        drive(2'd2, 1'b1, 32'h9ABCDEF0, 1'b0);
        #1;
        chk("R3 gnt low", {31'b0, cpu_gnt_o}, 32'd0);
        @(negedge clk);
        chk("R3 held data", bus_data_o, 32'h12345678);
        // release with policy off: last word stays
        drive(2'd0, 1'b0, 32'hFFFFFFFF, 1'b1);
        #1;
        chk("R2 gnt on ready", {31'b0, cpu_gnt_o}, 32'd1);
        @(negedge clk);
        chk("R5 keep after release", bus_data_o, 32'h12345678);
        chk("R9 valid drops", {31'b0, bus_valid_o}, 32'd0);

        // R1 reset in the middle, LFSR restarts (R6)
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid reset data", bus_data_o, 32'd0);
        chk("R1 mid reset valid", {31'b0, bus_valid_o}, 32'd0);
        rst = 1'b0;
        ref_lfsr = SEED;
        drive(2'd2, 1'b0, 32'hFFFFFFFF, 1'b1);
        @(negedge clk);
        chk("R6 seed first", bus_data_o, ref_lfsr);
        ref_lfsr = step_ref(ref_lfsr);
        @(negedge clk);
        chk("R6 second word", bus_data_o, ref_lfsr);

        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

endmodule